// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter that talks over a synchronous serial port. An active-low chip-select frames each transaction. The serial clock drives every register. The host sends a high start bit on the data input, followed by four address bits. These bits fill a multiplexer register, and the block decodes it into a single-ended flag and a channel index. After one sampling period the block runs a binary search. Each step presents a trial code to an external comparator and reads back one decision bit.

Each decision goes out on the serial data output on the falling clock edge that follows it, most significant bit first. A busy flag is high while the search runs. Once the search ends, the stored result can be replayed least significant bit first, and a shift-enable input gates this replay. The data input is only read while addressing is in progress. A tri-state enable for the output rises at the end of addressing, so the input and the output can share one wire.

Top module: `sar_serial_seq`

## Requirements
- R1: While cs_ni is high, every register is held cleared: do_en_o is 0, sars_o is 0, trial_o is 0, and sgl_o and chan_o are 0.
- R2: With cs_ni low, leading zeros on di_i are ignored. The first 1 is the start bit, and the next four bits (sgl, odd, sel1, sel0, in that order) are captured. Once addressing completes, sgl_o shows sgl and chan_o = {sel1, sel0, odd}.
- R3: At the falling edge that follows the rising edge which captured the last address bit, do_en_o goes to 1 and do_o drives 0 (the leading zero). do_en_o stays 1 until cs_ni rises.
- R4: sars_o rises on the rising edge after the sampling period and stays high for exactly 8 rising edges.
- R5: While sars_o is high, trial_o holds the decided upper bits, with the current trial bit set and all lower bits 0. A high cmp_i keeps the trial bit. Outside conversion, trial_o is 0.
- R6: Each decision sampled on a rising edge appears on do_o at the next falling edge, MSB first, so the stream equals the converted code.
- R7: di_i has no effect once addressing is complete. sgl_o, chan_o and the result stay unchanged however di_i toggles.
- R8: After the last decision, do_o keeps showing the LSB for as long as se_i is high.
- R9: Each rising edge with se_i low sends the next result bit, in the order bit 1 through bit 7. The LSB is not repeated.
- R10: After bit 7, the next se_i-low rising edge drives do_o low. do_o then stays low, whatever di_i does, until cs_ni goes high. A new conversion needs cs_ni to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip-select; high clears the block |
| di_i | input | 1 | Serial data in (start and address bits) |
| se_i | input | 1 | Shift-enable for the LSB-first replay |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above trial_o |
| trial_o | output | 8 | Trial code presented to the comparator |
| do_o | output | 1 | Serial data out |
| do_en_o | output | 1 | Output enable for the do_o driver |
| sars_o | output | 1 | Conversion in progress |
| sgl_o | output | 1 | Single-ended select from the address |
| chan_o | output | 3 | Decoded channel index |

## Verification
The hardest case is a transaction cut off partway. It takes chip-select rising in the middle of a search, followed by a clean transaction straight after. The bench does this by aborting after a few decisions and then starting a fresh conversion with another code, address and leading-zero count. This shows that no decided bit or address bit survives the clear. The shared-LSB hold takes a second deliberate move: shift-enable stays high for several edges after the final decision, then drops. Data-input noise is driven throughout the conversion and the replay to cover R7 and R10.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_ADDR,
    ST_SAMP,
    ST_CONV,
    ST_SHIFT,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/sar_addr_reg.sv
`timescale 1ns/1ps
module sar_addr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              di_i,
  output logic [ADDR_W-1:0] mux_o,
  output logic              hit_o,
  output logic              done_o
);
  // start bit travels to sr_q[ADDR_W]; shifting stops there
  logic [ADDR_W:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)            sr_q <= '0;
    else if (!sr_q[ADDR_W])  sr_q <= {sr_q[ADDR_W-1:0], di_i};
  end

  assign done_o = sr_q[ADDR_W];
  assign hit_o  = !sr_q[ADDR_W] && sr_q[ADDR_W-1];
  assign mux_o  = sr_q[ADDR_W-1:0];

  assert_mux_frozen_R7: assert property (@(posedge clk_i) disable iff (!arst_ni)
    done_o |=> $stable(mux_o));
endmodule

// File: rtl/sar_core.sv
`timescale 1ns/1ps
module sar_core
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             addr_hit_i,
  input  logic             cmp_i,
  input  logic             se_i,
  output logic [RES_W-1:0] trial_o,
  output logic             bit_o,
  output logic             oe_o,
  output logic             sars_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] sh_cnt_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-2:0] out_sr_q;
  logic             bit_q, oe_q, sars_q;
  logic [IDX_W:0]   sars_run_q;

  always_comb begin
    trial_o = '0;
    if (st_q == ST_CONV) begin
      trial_o        = res_q;
      trial_o[idx_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      st_q     <= ST_ADDR;
      idx_q    <= '0;
      sh_cnt_q <= '0;
      res_q    <= '0;
      out_sr_q <= '0;
      bit_q    <= 1'b0;
      oe_q     <= 1'b0;
      sars_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (addr_hit_i) begin
          st_q  <= ST_SAMP;
          oe_q  <= 1'b1;
          bit_q <= 1'b0;
        end
        ST_SAMP: begin
          st_q   <= ST_CONV;
          sars_q <= 1'b1;
          idx_q  <= IDX_TOP;
        end
        ST_CONV: begin
          res_q[idx_q] <= cmp_i;
          bit_q        <= cmp_i;
          if (idx_q == '0) begin
            st_q     <= ST_SHIFT;
            sars_q   <= 1'b0;
            out_sr_q <= res_q[RES_W-1:1];
            sh_cnt_q <= '0;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        ST_SHIFT: if (!se_i) begin
          if (sh_cnt_q == IDX_TOP) begin
            bit_q <= 1'b0;
            st_q  <= ST_DONE;
          end else begin
            bit_q    <= out_sr_q[0];
            out_sr_q <= {1'b0, out_sr_q[RES_W-2:1]};
            sh_cnt_q <= sh_cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign bit_o  = bit_q;
  assign oe_o   = oe_q;
  assign sars_o = sars_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    sars_run_q <= '0;
    else if (sars_q) sars_run_q <= sars_run_q + 1'b1;
    else             sars_run_q <= '0;
  end

  assert_sars_len_R4: assert property (@(posedge clk_i) disable iff (!arst_ni)
    sars_run_q <= (IDX_W+1)'(RES_W));
endmodule

// File: rtl/sar_out_stage.sv
`timescale 1ns/1ps
module sar_out_stage (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic bit_i,
  input  logic oe_i,
  output logic do_o,
  output logic oe_o
);
  always_ff @(negedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      do_o <= 1'b0;
      oe_o <= 1'b0;
    end else begin
      do_o <= bit_i;
      oe_o <= oe_i;
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq #(
  parameter int RES_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              di_i,
  input  logic              se_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  trial_o,
  output logic              do_o,
  output logic              do_en_o,
  output logic              sars_o,
  output logic              sgl_o,
  output logic [ADDR_W-2:0] chan_o
);
  logic              arst_n;
  logic [ADDR_W-1:0] mux;
  logic              hit, addr_done, bit_d, oe_d;

  // chip-select high holds everything cleared
  assign arst_n = rst_ni && !cs_ni;

  sar_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i(sclk_i), .arst_ni(arst_n), .di_i(di_i),
    .mux_o(mux), .hit_o(hit), .done_o(addr_done)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk_i(sclk_i), .arst_ni(arst_n), .addr_hit_i(hit), .cmp_i(cmp_i),
    .se_i(se_i), .trial_o(trial_o), .bit_o(bit_d), .oe_o(oe_d), .sars_o(sars_o)
  );

  sar_out_stage u_out (
    .clk_i(sclk_i), .arst_ni(arst_n), .bit_i(bit_d), .oe_i(oe_d),
    .do_o(do_o), .oe_o(do_en_o)
  );

  assign sgl_o  = mux[ADDR_W-1];
  assign chan_o = {mux[ADDR_W-3:0], mux[ADDR_W-2]};

  assert_cs_idle_R1: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |-> (!do_en_o && !sars_o && trial_o == '0));

  assert_conv_drives_R3: assert property (@(posedge sclk_i) disable iff (!arst_n)
    sars_o |-> do_en_o);

  assert_trial_live_R5: assert property (@(posedge sclk_i) disable iff (!arst_n)
    sars_o |-> (trial_o != '0));

  assert_addr_before_conv_R2: assert property (@(posedge sclk_i) disable iff (!arst_n)
    sars_o |-> addr_done);
endmodule

// File: tb/sar_serial_seq_bench.sv
`timescale 1ns/1ps
module sar_serial_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_s = 1'b1, di_s = 1'b0, se_s = 1'b1;
  logic [7:0] vin = '0;
  logic [7:0] trial;
  logic       cmp, do_w, do_en, sars, sgl;
  logic [2:0] chan;

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_sr = 0, m_k = 0, m_j = 0;
  bit m_do = 0, m_oe = 0, m_sars = 0;

  always #5 clk = ~clk;

  assign cmp = (vin >= trial);

  sar_serial_seq u_sar_serial_seq (
    .sclk_i(clk), .rst_ni(rst_n), .cs_ni(cs_s), .di_i(di_s), .se_i(se_s),
    .cmp_i(cmp), .trial_o(trial), .do_o(do_w), .do_en_o(do_en),
    .sars_o(sars), .sgl_o(sgl), .chan_o(chan)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_st = 0; m_sr = 0; m_k = 0; m_j = 0;
    m_do = 0; m_oe = 0; m_sars = 0;
  endtask

  task automatic model_edge();
    if (cs_s) return;
    case (m_st)
      0: begin
        m_sr = ((m_sr << 1) | int'(di_s)) & 31;
        if ((m_sr & 16) != 0) begin m_st = 1; m_oe = 1; m_do = 0; end
      end
      1: begin m_st = 2; m_sars = 1; m_k = 7; end
      2: begin
        m_do = vin[m_k];
        if (m_k == 0) begin m_st = 3; m_sars = 0; m_j = 1; end
        else m_k--;
      end
      3: if (!se_s) begin
        if (m_j == 8) begin m_do = 0; m_st = 4; end
        else begin m_do = vin[m_j]; m_j++; end
      end
      default: ;
    endcase
  endtask

  task automatic compare();
    string t_do;
    int exp_tr, mux;
    if (cs_s) t_do = "R1";
    else case (m_st)
      1: t_do = "R3";
      2: t_do = "R6";
      3: t_do = se_s ? "R8" : "R9";
      4: t_do = "R10";
      default: t_do = "R1";
    endcase
    chk(cs_s ? "R1 do_en" : "R3 do_en", int'(do_en), int'(m_oe));
    if (m_oe) chk(t_do, int'(do_w), int'(m_do));
    chk(cs_s ? "R1 sars" : "R4 sars", int'(sars), int'(m_sars));
    exp_tr = 0;
    if (m_st == 2) exp_tr = ((int'(vin) >> (m_k + 1)) << (m_k + 1)) | (1 << m_k);
    chk("R5 trial", int'(trial), exp_tr);
    mux = (m_st >= 1) ? (m_sr & 15) : 0;
    if (m_st >= 1 || cs_s) begin
      chk(m_st >= 2 ? "R7 sgl" : "R2 sgl", int'(sgl), (mux >> 3) & 1);
      chk(m_st >= 2 ? "R7 chan" : "R2 chan", int'(chan), ((mux & 3) << 1) | ((mux >> 2) & 1));
    end
  endtask

  // inputs change 2 ns after a falling edge; outputs checked at the same point
  task automatic step(logic d, logic s, logic c);
    di_s = d; se_s = s; cs_s = c;
    if (c) model_clear();
    @(posedge clk);
    #1 model_edge();
    #6 compare();
  endtask

  task automatic conv_run(logic [7:0] code, logic [3:0] addr, int lead, int hold,
                          bit noise, int abort_at);
    vin = code;
    for (int i = 0; i < lead; i++) step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    for (int i = 3; i >= 0; i--) step(addr[i], 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) begin
      if (i == abort_at) begin
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        return;
      end
      step(noise ? logic'(i % 2) : 1'b0, 1'b1, 1'b0);
    end
    for (int i = 0; i < hold; i++) step(noise ? 1'b1 : 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 11; i++) step(logic'(i % 3 == 0), 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #22;
    chk("R1 reset do_en", int'(do_en), 0);
    chk("R1 reset sars", int'(sars), 0);
    chk("R1 reset trial", int'(trial), 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    conv_run(8'hA5, 4'b1100, 2, 0, 1'b1, 99);
    conv_run(8'h00, 4'b0011, 0, 3, 1'b1, 99);
    conv_run(8'hFF, 4'b1011, 1, 0, 1'b0, 99);
    conv_run(8'h80, 4'b0101, 3, 1, 1'b1, 99);
    conv_run(8'h01, 4'b1110, 0, 2, 1'b1, 99);
    conv_run(8'h5A, 4'b1111, 1, 0, 1'b1, 5);
    conv_run(8'h3C, 4'b0110, 0, 4, 1'b1, 99);
    conv_run(8'hC3, 4'b1001, 2, 0, 1'b0, 0);
    conv_run(8'h7E, 4'b0000, 4, 0, 1'b1, 99);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule